// File: doc/BRIEF.md
# Oscillator Band Autoselect Controller

This block chooses which of 24 oscillator bands drives a PLL. In manual mode it passes a programmed 5-bit band index straight to the oscillator bank. Software can also capture a tuning-voltage ADC reading into a readback register, using an enable bit and a one-cycle latch strobe.

In automatic mode, a start pulse begins a search. The register interface raises this pulse when the low divider word is written. The search begins at the programmed band. After each band change the controller waits a programmable number of settle cycles. It then judges the 3-bit tuning-voltage code and does one of three things:

- accepts the band,
- steps one band up or down, or
- gives up.

Two flags report whether the search has ended and whether it found a band. The code seen at the final judgement is kept for readback.

Top module: `vco_band_selector`

## Requirements
- R1: With `auto_en` low, `active_band` equals `prog_band`, `search_done` reads 1 and `search_ok` reads 0 (one clock after `auto_en` falls).
- R2: A `start` pulse while `auto_en` is high loads `prog_band` as the first band tried. A `start` pulse while `auto_en` is low has no effect on the outputs.
- R3: `search_done` reads 0 from the clock edge that accepts `start` until the search ends. It then reads 1, whether or not the search succeeded.
- R4: `search_ok` rises only when the judged code is a narrow window code, 3'b010 or 3'b101. It is 0 after a failed search, and it clears one clock after `auto_en` falls.
- R5: Codes 3'b000 and 3'b001 step the band index up by one. Codes 3'b110 and 3'b111 step it down by one. A search never moves the band by more than one per step.
- R6: Each band is held for `settle_cycles` + 1 clocks before its code is judged. A search that visits k bands sets `search_done` exactly k*(`settle_cycles`+1) clock edges after the edge that accepts `start`.
- R7: A step that would go above band 23 or below band 0 ends the search with `search_ok` = 0. The last band tried stays active.
- R8: A step onto a band already tried in the same search ends it with `search_ok` = 0. The last band tried stays active.
- R9: In manual mode, `adc_latch` captures `tune_code` into `code_readback` only while `adc_en` is 1. Without `adc_en` the strobe is ignored.
- R10: In automatic mode, `code_readback` holds the code judged at the last evaluation of a search.
- R11: After reset, `search_done` = 1, `search_ok` = 0 and `code_readback` = 3'b000.
- R12: A `start` with `prog_band` above 23 ends at once: `search_done` stays 1, `search_ok` is 0, and no band is stepped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_band | input | 5 | Programmed band index (manual band or search start) |
| auto_en | input | 1 | 1 selects automatic search |
| start | input | 1 | One-cycle search trigger from the divider word write |
| adc_en | input | 1 | Manual-mode ADC enable |
| adc_latch | input | 1 | Manual-mode capture strobe |
| settle_cycles | input | 8 | Clocks to wait after a band change, minus one |
| tune_code | input | 3 | Tuning-voltage window code from the ADC |
| active_band | output | 5 | Band index driven to the oscillator bank |
| search_done | output | 1 | 1 when no search is running |
| search_ok | output | 1 | 1 when the last search found a band |
| code_readback | output | 3 | Latched ADC code |

## Verification
Several internal faults show up at the ports within one settle period of their cause:

- A wrong step direction or a lost visited mark drives `active_band` to a different final value.
- A corrupted settle counter moves the cycle in which `search_done` rises; the bench checks that cycle exactly.
- A mis-decoded window code sets `search_ok` on a non-window band, or never sets it.

Range-limit and revisit failures are each forced by a bench tuning model that pushes the search into them. The final band and the readback code then expose any fault in the stop logic as soon as the flag rises.

// File: rtl/vas_pkg.sv
package vas_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_SETTLE = 1'b1
    } srch_state_e;

    typedef struct packed {
        logic done;
        logic ok;
    } srch_flags_t;

    // Narrow acceptance window of the tune-voltage code
    function automatic logic code_in_window(input logic [2:0] code);
        return (code == 3'b010) || (code == 3'b101);
    endfunction

    // Low-side codes push the index upward, high-side codes downward
    function automatic logic code_steps_up(input logic [2:0] code);
        return (code == 3'b000) || (code == 3'b001);
    endfunction

endpackage

// File: rtl/vas_settle_timer.sv
module vas_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                  cnt_q <= '0;
        else if (load)            cnt_q <= load_val;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R6
    settle_countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/vas_band_history.sv
module vas_band_history #(
    parameter int NUM_BANDS = 24,
    parameter int BAND_W    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              mark,
    input  logic [BAND_W-1:0] mark_idx,
    input  logic [BAND_W-1:0] query_idx,
    output logic              seen
);
    logic [NUM_BANDS-1:0] tried_q;

    for (genvar i = 0; i < NUM_BANDS; i++) begin : g_slot
        logic hit;
        assign hit = mark && (mark_idx == BAND_W'(i));
        always_ff @(posedge clk) begin
            if (rst)        tried_q[i] <= 1'b0;
            else if (clear) tried_q[i] <= hit;
            else if (hit)   tried_q[i] <= 1'b1;
        end
    end

    always_comb begin
        seen = 1'b0;
        for (int j = 0; j < NUM_BANDS; j++)
            if (query_idx == BAND_W'(j)) seen = tried_q[j];
    end

    // R8
    mark_sticks_chk: assert property (@(posedge clk) disable iff (rst)
        (mark && !clear && query_idx == mark_idx) |=> seen || (query_idx != $past(query_idx)) || clear);

endmodule

// File: rtl/vas_next_band.sv
module vas_next_band
    import vas_pkg::*;
#(
    parameter int NUM_BANDS = 24,
    parameter int BAND_W    = 5
) (
    input  logic [BAND_W-1:0] cur_band,
    input  logic [2:0]        code,
    output logic [BAND_W-1:0] next_band,
    output logic              out_of_range
);
    localparam logic [BAND_W-1:0] TOP_BAND = BAND_W'(NUM_BANDS - 1);

    logic go_up;
    assign go_up = code_steps_up(code);

    always_comb begin
        if (go_up) begin
            next_band    = cur_band + 1'b1;
            out_of_range = (cur_band >= TOP_BAND);
        end else begin
            next_band    = cur_band - 1'b1;
            out_of_range = (cur_band == '0) || (cur_band > TOP_BAND);
        end
    end

endmodule

// File: rtl/vco_band_selector.sv
module vco_band_selector
    import vas_pkg::*;
#(
    parameter int NUM_BANDS = 24,
    parameter int BAND_W    = 5,
    parameter int CNT_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BAND_W-1:0] prog_band,
    input  logic              auto_en,
    input  logic              start,
    input  logic              adc_en,
    input  logic              adc_latch,
    input  logic [CNT_W-1:0]  settle_cycles,
    input  logic [2:0]        tune_code,
    output logic [BAND_W-1:0] active_band,
    output logic              search_done,
    output logic              search_ok,
    output logic [2:0]        code_readback
);
    localparam logic [BAND_W-1:0] TOP_BAND = BAND_W'(NUM_BANDS - 1);

    srch_state_e       state_q;
    srch_flags_t       flags_q;
    logic [BAND_W-1:0] band_q;
    logic [2:0]        rb_q;

    logic              launch, prog_valid, expired, eval;
    logic              accept, stop_fail, step;
    logic [BAND_W-1:0] next_band;
    logic              oor, seen;

    assign prog_valid = (prog_band <= TOP_BAND);
    assign launch     = auto_en && start;
    assign eval       = auto_en && !start && (state_q == ST_SETTLE) && expired;
    assign accept     = eval && code_in_window(tune_code);
    assign stop_fail  = eval && !accept && (oor || seen);
    assign step       = eval && !accept && !oor && !seen;

    vas_next_band #(.NUM_BANDS(NUM_BANDS), .BAND_W(BAND_W)) i_next (
        .cur_band     (band_q),
        .code         (tune_code),
        .next_band    (next_band),
        .out_of_range (oor)
    );

    vas_band_history #(.NUM_BANDS(NUM_BANDS), .BAND_W(BAND_W)) i_hist (
        .clk       (clk),
        .rst       (rst),
        .clear     (launch),
        .mark      ((launch && prog_valid) || step),
        .mark_idx  (launch ? prog_band : next_band),
        .query_idx (next_band),
        .seen      (seen)
    );

    vas_settle_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     ((launch && prog_valid) || step),
        .load_val (settle_cycles),
        .expired  (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            band_q  <= '0;
            flags_q <= '{done: 1'b1, ok: 1'b0};
            rb_q    <= 3'b000;
        end else if (!auto_en) begin
            state_q <= ST_IDLE;
            band_q  <= prog_band;
            flags_q <= '{done: 1'b1, ok: 1'b0};
            if (adc_en && adc_latch) rb_q <= tune_code;
        end else if (start) begin
            band_q     <= prog_band;
            flags_q.ok <= 1'b0;
            if (prog_valid) begin
                state_q      <= ST_SETTLE;
                flags_q.done <= 1'b0;
            end else begin
                state_q      <= ST_IDLE;
                flags_q.done <= 1'b1;
            end
        end else if (eval) begin
            rb_q <= tune_code;
            if (accept) begin
                state_q <= ST_IDLE;
                flags_q <= '{done: 1'b1, ok: 1'b1};
            end else if (stop_fail) begin
                state_q <= ST_IDLE;
                flags_q <= '{done: 1'b1, ok: 1'b0};
            end else begin
                band_q <= next_band;
            end
        end
    end

    assign active_band   = auto_en ? band_q : prog_band;
    assign search_done   = flags_q.done;
    assign search_ok     = flags_q.ok;
    assign code_readback = rb_q;

    // R4
    ok_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        search_ok |-> search_done);

    // R4
    ok_from_window_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(search_ok) |-> code_in_window($past(tune_code)));

    // R3
    busy_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SETTLE) |-> !search_done);

    // R5
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SETTLE && auto_en && !start) |=>
            (band_q == $past(band_q) || band_q == $past(band_q) + 1'b1 ||
             band_q == $past(band_q) - 1'b1));

    // R7
    band_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SETTLE) |-> (band_q <= TOP_BAND));

endmodule

// File: tb/test_vco_band_selector.sv
module test_vco_band_selector;
    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] prog_band;
    logic       auto_en, start, adc_en, adc_latch;
    logic [7:0] settle_cycles;
    logic [2:0] tune_code;
    logic [4:0] active_band;
    logic       search_done, search_ok;
    logic [2:0] code_readback;

    int vectors = 0;
    int errors  = 0;

    // tuning model: 0 fixed code, 1 target band, 2 oscillating, 3 always high
    int         model_mode = 0;
    int         target     = 0;
    logic [2:0] fixed_code = 3'b000;
    logic [2:0] win_code   = 3'b010;

    always #5 clk = ~clk;

    vco_band_selector i_vco_band_selector (
        .clk(clk), .rst(rst), .prog_band(prog_band), .auto_en(auto_en),
        .start(start), .adc_en(adc_en), .adc_latch(adc_latch),
        .settle_cycles(settle_cycles), .tune_code(tune_code),
        .active_band(active_band), .search_done(search_done),
        .search_ok(search_ok), .code_readback(code_readback)
    );

    always_comb begin
        int b;
        b = int'(active_band);
        case (model_mode)
            1: begin
                if (b < target - 1)       tune_code = 3'b000;
                else if (b == target - 1) tune_code = 3'b001;
                else if (b == target)     tune_code = win_code;
                else if (b == target + 1) tune_code = 3'b110;
                else                      tune_code = 3'b111;
            end
            2: tune_code = (b <= target) ? 3'b001 : 3'b110;
            3: tune_code = 3'b111;
            default: tune_code = fixed_code;
        endcase
    end

    task automatic check(input string req, input int actual, input int expected);
        vectors++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic pulse_start(input logic [4:0] band);
        @(negedge clk);
        prog_band = band;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000; i++) begin
            if (search_done) return;
            @(negedge clk);
        end
        check("R3 search never ended", 0, 1);
    endtask

    task automatic t_reset();
        rst = 1'b1; prog_band = 5'd3; auto_en = 1'b0; start = 1'b0;
        adc_en = 1'b0; adc_latch = 1'b0; settle_cycles = 8'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 done after reset", search_done, 1);
        check("R11 ok after reset", search_ok, 0);
        check("R11 readback after reset", code_readback, 0);
        check("R1 manual band", active_band, 3);
    endtask

    task automatic t_manual_latch();
        model_mode = 0; fixed_code = 3'b101;
        @(negedge clk); adc_latch = 1'b1; adc_en = 1'b0;
        @(negedge clk); adc_latch = 1'b0;
        check("R9 latch ignored without enable", code_readback, 0);
        adc_en = 1'b1; adc_latch = 1'b1;
        @(negedge clk); adc_latch = 1'b0; adc_en = 1'b0;
        check("R9 latch with enable", code_readback, 5);
        prog_band = 5'd17;
        @(negedge clk);
        check("R1 band follows program", active_band, 17);
    endtask

    task automatic t_start_manual();
        pulse_start(5'd9);
        repeat (4) @(negedge clk);
        check("R2 start ignored done", search_done, 1);
        check("R2 start ignored ok", search_ok, 0);
        check("R2 start ignored band", active_band, 9);
        auto_en = 1'b1;
        @(negedge clk);
        check("R2 auto idle holds band", active_band, 9);
    endtask

    task automatic t_up_timing();
        model_mode = 1; target = 8; win_code = 3'b010; settle_cycles = 8'd3;
        auto_en = 1'b1;
        pulse_start(5'd5);
        check("R2 first band is programmed", active_band, 5);
        check("R3 done low at start", search_done, 0);
        repeat (15) @(negedge clk);
        check("R6 done still low before deadline", search_done, 0);
        @(negedge clk);
        check("R6 done at deadline", search_done, 1);
        check("R4 ok after find", search_ok, 1);
        check("R5 upward search band", active_band, 8);
        check("R10 readback window code", code_readback, 2);
    endtask

    task automatic t_down_win101();
        model_mode = 1; target = 10; win_code = 3'b101; settle_cycles = 8'd1;
        pulse_start(5'd15);
        wait_done();
        check("R5 downward search band", active_band, 10);
        check("R4 ok on code 101", search_ok, 1);
        check("R10 readback 101", code_readback, 5);
    endtask

    task automatic t_bad_prog();
        pulse_start(5'd27);
        check("R12 done stays high", search_done, 1);
        check("R12 ok cleared", search_ok, 0);
        repeat (3) @(negedge clk);
        check("R12 no stepping", active_band, 27);
    endtask

    task automatic t_revisit();
        model_mode = 2; target = 6; settle_cycles = 8'd0;
        pulse_start(5'd6);
        wait_done();
        check("R8 revisit fails ok", search_ok, 0);
        check("R8 last band kept", active_band, 7);
        check("R10 readback last code", code_readback, 6);
    endtask

    task automatic t_range_high();
        model_mode = 1; target = 30; settle_cycles = 8'd2;
        pulse_start(5'd20);
        wait_done();
        check("R7 upper limit ok", search_ok, 0);
        check("R7 upper limit band", active_band, 23);
        check("R10 readback at upper limit", code_readback, 0);
    endtask

    task automatic t_range_low();
        model_mode = 3; settle_cycles = 8'd0;
        pulse_start(5'd2);
        wait_done();
        check("R7 lower limit ok", search_ok, 0);
        check("R7 lower limit band", active_band, 0);
    endtask

    task automatic t_auto_off();
        model_mode = 1; target = 12; win_code = 3'b010; settle_cycles = 8'd0;
        pulse_start(5'd11);
        wait_done();
        check("R4 ok before disable", search_ok, 1);
        auto_en = 1'b0; prog_band = 5'd4;
        @(negedge clk);
        check("R4 ok cleared when disabled", search_ok, 0);
        check("R1 band back to program", active_band, 4);
        check("R1 done when disabled", search_done, 1);
    endtask

    initial begin
        t_reset();
        t_manual_latch();
        t_start_manual();
        t_up_timing();
        t_down_win101();
        t_bad_prog();
        t_revisit();
        t_range_high();
        t_range_low();
        t_auto_off();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule